// File: doc/BRIEF.md
# Chained SPI Register Command Slave

This block is an SPI mode-0 slave in front of a tiny register bank: two 8-bit wiper position registers and one 8-bit control register. Its serial path is a 16-bit delay line from the data input to the data output. Several slaves can therefore share one chip select, with each one's output feeding the next one's input, and the host clocks sixteen bits per device in every frame.

Nothing happens while chip select is low except shifting. When chip select rises, the slave takes the sixteen bits that are still in its delay line as an instruction byte followed by a data byte. It then performs a write, or places a read answer back into the delay line. That answer leaves the output at the start of the next frame, while the host clocks NOP frames. The output can drive in push-pull or open-drain fashion, and it is released whenever chip select is high.

The serial pins are sampled by the system clock `clk`. Each SCK and chip-select level must be held for at least two `clk` cycles. Chip select may not change in the same `clk` cycle as an SCK edge.

Top module: `dcp_spi_regif`

## Requirements
- R1: Reset sets both wiper registers and the control register to 0x40, and the output enable is low.
- R2: SDI is sampled on SCK rising edges, MSB first. SDO changes only on SCK falling edges and on the chip-select falling edge. Within a frame, SDO carries the bit that entered SDI 16 rising edges earlier. The first bit of a frame appears at the chip-select falling edge.
- R3: In the instruction byte, bits 7:5 are the opcode and bits 4:0 are the address. Opcode 110 writes the data byte to address 00000 (wiper 0), 00001 (wiper 1) or 10000 (control).
- R4: Opcode 011 writes the control register whatever the address bits hold. The control register keeps only data bits 6 and 1; its other bits always read 0.
- R5: Opcode 100 (mapped address) or opcode 001 (control, address bits ignored) loads the delay line with a response word. Its first byte is 111 followed by the register's address (10000 for control), and its second byte is the register value. The word is shifted out MSB first during the next frame.
- R6: Registers change only on the chip-select rising edge that ends a frame. They never change while chip select is low.
- R7: A frame with a bit count that is zero or not a multiple of 16, an unlisted opcode, or an unmapped address changes no register and loads no response. The delay line keeps the bits last received.
- R8: For frames longer than 16 bits, only the last 16 bits are executed; earlier bits pass out on SDO.
- R9: While chip select is high, SDO is not driven (output enable low).
- R10: When control bit 1 is 1 (open drain), SDO is enabled only while the output bit is 0, and then it drives 0. When control bit 1 is 0 (push-pull), SDO is enabled throughout an accepted frame.
- R11: After reset, the slave ignores SCK, chip-select rising edges and output enable until it has seen chip select go from high to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out value |
| spi_sdo_oe | output | 1 | Output enable for the SDO pad |
| wiper_pos_o | output | 16 | Wiper i position in bits 8i+7:8i |
| ctl_o | output | 8 | Control register (bit 6 shutdown control, bit 1 open-drain select) |

## Verification
If the bit counter is wrong, a frame of the wrong length executes, or a valid frame is dropped, and a register port differs two system clocks after chip select rises. If the delay line is corrupted, the fault shows on SDO in the following frame: the response word or the passed-through bits differ on the first wrong SCK falling edge. If the arming flag or the output mode is wrong, the output enable differs at the next chip-select edge or at the next output bit. So the bench compares every port after each half SCK period against a behavioural model.

// File: rtl/dcp_spi_pkg.sv
package dcp_spi_pkg;
    localparam int DATA_W     = 8;
    localparam int OP_W       = 3;
    localparam int ADDR_W     = 5;
    localparam int FRAME_W    = OP_W + ADDR_W + DATA_W;
    localparam int NUM_WIPERS = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'b000,
        OP_RD_CTL = 3'b001,
        OP_WR_CTL = 3'b011,
        OP_RD_REG = 3'b100,
        OP_WR_REG = 3'b110,
        OP_RESP   = 3'b111
    } opcode_e;

    localparam logic [ADDR_W-1:0] ADDR_CTL  = 5'h10;
    localparam logic [DATA_W-1:0] WIPER_RST = 8'h40;
    localparam logic [DATA_W-1:0] CTL_RST   = 8'h40;
    localparam logic [DATA_W-1:0] CTL_KEEP  = 8'h42;
    localparam int                ODRAIN_BIT = 1;
endpackage

// File: rtl/dcp_frame_shifter.sv
module dcp_frame_shifter
    import dcp_spi_pkg::*;
#(
    parameter int WIDTH = FRAME_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             sdi,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] frame_o,
    output logic             exec_o,
    output logic             sdo_bit_o,
    output logic             armed_o
);
    localparam int CNT_W = $clog2(WIDTH);

    typedef struct packed {
        logic             sck_prev;
        logic             cs_prev;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             got_bits;
        logic [WIDTH-1:0] sh;
        logic             sdo;
    } shf_t;

    shf_t st_q, st_d;
    logic cs_fall, cs_rise, sck_rise, sck_fall, in_frame;

    always_comb begin
        st_d     = st_q;
        in_frame = ~cs_n & ~st_q.cs_prev & st_q.armed;
        cs_fall  = st_q.cs_prev & ~cs_n;
        cs_rise  = ~st_q.cs_prev & cs_n;
        sck_rise = in_frame & sck & ~st_q.sck_prev;
        sck_fall = in_frame & ~sck & st_q.sck_prev;
        exec_o   = cs_rise & st_q.armed & st_q.got_bits & (st_q.cnt == '0);

        st_d.sck_prev = sck;
        st_d.cs_prev  = cs_n;
        if (cs_fall) begin
            st_d.armed    = 1'b1;
            st_d.cnt      = '0;
            st_d.got_bits = 1'b0;
            st_d.sdo      = st_q.sh[WIDTH-1];
        end
        if (sck_rise) begin
            st_d.sh       = {st_q.sh[WIDTH-2:0], sdi};
            st_d.got_bits = 1'b1;
            st_d.cnt      = (st_q.cnt == CNT_W'(WIDTH-1)) ? '0 : st_q.cnt + 1'b1;
        end
        if (sck_fall) begin
            st_d.sdo = st_q.sh[WIDTH-1];
        end
        if (load_en) begin
            st_d.sh = load_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_o   = st_q.sh;
    assign sdo_bit_o = st_q.sdo;
    assign armed_o   = st_q.armed;

    // R2
    sdo_quiet_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && !load_en) |=> (st_q.sdo == $past(st_q.sdo)));
endmodule

// File: rtl/dcp_cmd_decode.sv
module dcp_cmd_decode
    import dcp_spi_pkg::*;
#(
    parameter int NREG = NUM_WIPERS + 1
) (
    input  logic                   exec_i,
    input  logic [FRAME_W-1:0]     frame_i,
    input  logic [NREG*DATA_W-1:0] regs_i,
    output logic [NREG-1:0]        wr_sel_o,
    output logic [DATA_W-1:0]      wr_data_o,
    output logic                   rd_load_o,
    output logic [FRAME_W-1:0]     rd_word_o
);
    localparam int CTL_IDX = NREG - 1;

    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [NREG-1:0]   tgt, wsel, rsel;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        op   = frame_i[FRAME_W-1 -: OP_W];
        addr = frame_i[DATA_W +: ADDR_W];
        for (int i = 0; i < NREG; i++) begin
            if (i == CTL_IDX) tgt[i] = (addr == ADDR_CTL);
            else              tgt[i] = (addr == ADDR_W'(i));
        end
        wsel = '0;
        rsel = '0;
        case (op)
            OP_WR_REG: wsel = tgt;
            OP_RD_REG: rsel = tgt;
            OP_WR_CTL: wsel[CTL_IDX] = 1'b1;
            OP_RD_CTL: rsel[CTL_IDX] = 1'b1;
            default: ;
        endcase
        rd_addr = '0;
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rsel[i]) begin
                rd_data = rd_data | regs_i[i*DATA_W +: DATA_W];
                rd_addr = rd_addr | ((i == CTL_IDX) ? ADDR_CTL : ADDR_W'(i));
            end
        end
        wr_sel_o  = exec_i ? wsel : '0;
        wr_data_o = frame_i[DATA_W-1:0];
        rd_load_o = exec_i & (|rsel);
        rd_word_o = {OP_RESP, rd_addr, rd_data};
    end
endmodule

// File: rtl/dcp_reg_bank.sv
module dcp_reg_bank
    import dcp_spi_pkg::*;
#(
    parameter int NW = NUM_WIPERS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NW:0]            wr_sel_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    output logic [NW*DATA_W-1:0]   wiper_o,
    output logic [DATA_W-1:0]      ctl_o
);
    typedef struct packed {
        logic [NW-1:0][DATA_W-1:0] wpos;
        logic [DATA_W-1:0]         ctl;
    } bank_t;

    bank_t bk_q, bk_d;

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < NW; i++) begin
            if (wr_sel_i[i]) bk_d.wpos[i] = wr_data_i;
        end
        if (wr_sel_i[NW]) bk_d.ctl = wr_data_i & CTL_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.wpos <= {NW{WIPER_RST}};
            bk_q.ctl  <= CTL_RST;
        end else begin
            bk_q <= bk_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NW; g++) begin : g_out
            assign wiper_o[g*DATA_W +: DATA_W] = bk_q.wpos[g];
        end
    endgenerate
    assign ctl_o = bk_q.ctl;

    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel_i));
    // R4
    ctl_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o & ~CTL_KEEP) == '0);
endmodule

// File: rtl/dcp_sdo_drive.sv
module dcp_sdo_drive (
    input  logic cs_n,
    input  logic armed,
    input  logic bit_i,
    input  logic odrain,
    output logic sdo_o,
    output logic sdo_oe
);
    always_comb begin
        sdo_oe = ~cs_n & armed & (~odrain | ~bit_i);
        sdo_o  = odrain ? 1'b0 : bit_i;
    end
endmodule

// File: rtl/dcp_spi_regif.sv
module dcp_spi_regif
    import dcp_spi_pkg::*;
#(
    parameter int NW = NUM_WIPERS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_sdi,
    output logic                 spi_sdo,
    output logic                 spi_sdo_oe,
    output logic [NW*DATA_W-1:0] wiper_pos_o,
    output logic [DATA_W-1:0]    ctl_o
);
    logic [FRAME_W-1:0] frame, rd_word;
    logic               exec, sdo_bit, armed, rd_load;
    logic [NW:0]        wr_sel;
    logic [DATA_W-1:0]  wr_data;

    dcp_frame_shifter #(.WIDTH(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .sdi(spi_sdi),
        .load_en(rd_load), .load_word(rd_word), .frame_o(frame), .exec_o(exec),
        .sdo_bit_o(sdo_bit), .armed_o(armed)
    );

    dcp_cmd_decode #(.NREG(NW + 1)) u_dec (
        .exec_i(exec), .frame_i(frame), .regs_i({ctl_o, wiper_pos_o}),
        .wr_sel_o(wr_sel), .wr_data_o(wr_data), .rd_load_o(rd_load), .rd_word_o(rd_word)
    );

    dcp_reg_bank #(.NW(NW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .wiper_o(wiper_pos_o), .ctl_o(ctl_o)
    );

    dcp_sdo_drive u_drv (
        .cs_n(spi_cs_n), .armed(armed), .bit_i(sdo_bit), .odrain(ctl_o[ODRAIN_BIT]),
        .sdo_o(spi_sdo), .sdo_oe(spi_sdo_oe)
    );

    // R9
    sdo_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sdo_oe);
    // R10
    odrain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[ODRAIN_BIT] && spi_sdo_oe) |-> !spi_sdo);
    // R6
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(spi_cs_n) |-> ($stable(wiper_pos_o) && $stable(ctl_o)));
    // R11
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (wr_sel == '0 && !rd_load));
endmodule

// File: tb/dcp_spi_regif_tb.sv
module dcp_spi_regif_tb;
    import dcp_spi_pkg::*;
    localparam int NW = NUM_WIPERS;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [NW*8-1:0] wpos;
    logic [7:0] ctl;

    always #10ns clk = ~clk;

    dcp_spi_regif u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_sdi(sdi),
        .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .wiper_pos_o(wpos), .ctl_o(ctl)
    );

    int vectors = 0, miscompares = 0;
    bit mq[$];
    int m_cnt;
    bit m_got, m_armed, m_sdo;
    logic [7:0] m_w[NW];
    logic [7:0] m_ctl;
    logic [63:0] rx;

    function automatic logic [7:0] wp(input int i);
        return wpos[i*8 +: 8];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit exp_oe;
        exp_oe = !cs_n && m_armed && (!m_ctl[1] || !m_sdo);
        check(sdo_oe === exp_oe, "R9", "sdo_oe", 32'(sdo_oe), 32'(exp_oe));
        if (exp_oe) check(sdo === (m_ctl[1] ? 1'b0 : m_sdo), "R2", "sdo", 32'(sdo), 32'(m_sdo));
        for (int i = 0; i < NW; i++) check(wp(i) === m_w[i], "R6", "wiper", 32'(wp(i)), 32'(m_w[i]));
        check(ctl === m_ctl, "R6", "ctl", 32'(ctl), 32'(m_ctl));
    endtask

    task automatic step(input int n = 4);
        repeat (n) @(negedge clk);
        compare_all();
    endtask

    task automatic model_reset();
        mq.delete();
        for (int i = 0; i < 16; i++) mq.push_back(1'b0);
        m_cnt = 0; m_got = 0; m_armed = 0; m_sdo = 0;
        for (int i = 0; i < NW; i++) m_w[i] = 8'h40;
        m_ctl = 8'h40;
    endtask

    task automatic model_exec();
        logic [15:0] w;
        int op, a, t;
        logic [7:0] val;
        logic [15:0] r;
        w = 16'h0;
        foreach (mq[i]) w = {w[14:0], mq[i]};
        op = int'(w[15:13]); a = int'(w[12:8]);
        t = (a < NW) ? a : ((a == 16) ? NW : -1);
        if (op == 3'b011) t = NW;
        if (op == 3'b001) t = NW;
        if ((op == 3'b110 || op == 3'b011) && t >= 0) begin
            if (t == NW) m_ctl = w[7:0] & 8'h42;
            else m_w[t] = w[7:0];
        end else if ((op == 3'b100 || op == 3'b001) && t >= 0) begin
            val = (t == NW) ? m_ctl : m_w[t];
            r = {3'b111, (t == NW) ? 5'h10 : 5'(t), val};
            mq.delete();
            for (int i = 15; i >= 0; i--) mq.push_back(r[i]);
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        m_armed = 1; m_cnt = 0; m_got = 0; m_sdo = mq[0];
        step();
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        if (m_armed && m_got && (m_cnt % 16) == 0) model_exec();
        step();
    endtask

    task automatic shift_bits(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sdi = v[n-1-i];
            step();
            sck = 1'b1;
            if (m_armed) begin
                mq.push_back(sdi);
                void'(mq.pop_front());
                m_cnt++; m_got = 1;
            end
            step();
            rx = {rx[62:0], sdo_oe ? sdo : 1'b1};
            sck = 1'b0;
            if (m_armed) m_sdo = mq[0];
            step();
        end
    endtask

    task automatic frame(input logic [63:0] v, input int n);
        cs_low();
        shift_bits(v, n);
        cs_high();
    endtask

    task automatic hw_reset(input logic cs_level);
        rst_n = 1'b0; cs_n = cs_level; sck = 1'b0;
        model_reset();
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rx = '0;
        hw_reset(1'b1);
        // R1 reset state
        check(wp(0) == 8'h40, "R1", "w0", 32'(wp(0)), 32'h40);
        check(wp(1) == 8'h40, "R1", "w1", 32'(wp(1)), 32'h40);
        check(ctl == 8'h40, "R1", "ctl", 32'(ctl), 32'h40);
        check(sdo_oe == 1'b0, "R1", "oe", 32'(sdo_oe), 0);

        // R3 register writes
        frame(64'hC05A, 16);
        check(wp(0) == 8'h5A, "R3", "w0", 32'(wp(0)), 32'h5A);
        frame(64'hC1A5, 16);
        check(wp(1) == 8'hA5, "R3", "w1", 32'(wp(1)), 32'hA5);
        // R4 control writes and masking
        frame(64'hD0FF, 16);
        check(ctl == 8'h42, "R4", "ctl", 32'(ctl), 32'h42);
        frame(64'h7700, 16);
        check(ctl == 8'h00, "R4", "ctl", 32'(ctl), 32'h00);
        frame(64'h6040, 16);
        check(ctl == 8'h40, "R4", "ctl", 32'(ctl), 32'h40);

        // R5 read responses
        frame(64'h8100, 16);
        frame(64'h0000, 16);
        check(rx[15:0] == 16'hE1A5, "R5", "resp w1", 32'(rx[15:0]), 32'hE1A5);
        frame(64'h3F00, 16);
        frame(64'h0000, 16);
        check(rx[15:0] == 16'hF040, "R5", "resp ctl", 32'(rx[15:0]), 32'hF040);

        // R7 invalid frames
        frame(64'hC03, 12);
        check(wp(0) == 8'h5A, "R7", "w0 12 bits", 32'(wp(0)), 32'h5A);
        frame(64'h0C033, 17);
        check(wp(0) == 8'h5A, "R7", "w0 17 bits", 32'(wp(0)), 32'h5A);
        frame(64'h4033, 16);
        check(wp(0) == 8'h5A && wp(1) == 8'hA5 && ctl == 8'h40, "R7", "bad op", 32'(wp(0)), 32'h5A);
        frame(64'hC233, 16);
        check(wp(0) == 8'h5A && wp(1) == 8'hA5 && ctl == 8'h40, "R7", "bad addr", 32'(wp(1)), 32'hA5);
        frame(64'h8533, 16);
        frame(64'h0000, 16);
        check(rx[15:0] == 16'h8533, "R7", "no resp", 32'(rx[15:0]), 32'h8533);

        // R6 nothing changes before chip select rises
        cs_low();
        shift_bits(64'hC077, 16);
        check(wp(0) == 8'h5A, "R6", "w0 mid", 32'(wp(0)), 32'h5A);
        cs_high();
        check(wp(0) == 8'h77, "R6", "w0 end", 32'(wp(0)), 32'h77);

        // R8 long frame, R2 delay line
        frame(64'hC011C122, 32);
        check(rx[15:0] == 16'hC011, "R2", "passthru", 32'(rx[15:0]), 32'hC011);
        check(wp(1) == 8'h22 && wp(0) == 8'h77, "R8", "last16", 32'(wpos), 32'h2277);

        // R9 released while deselected
        check(sdo_oe == 1'b0, "R9", "oe cs high", 32'(sdo_oe), 0);

        // R10 open drain
        frame(64'hD042, 16);
        check(ctl == 8'h42, "R10", "ctl", 32'(ctl), 32'h42);
        frame(64'h8100, 16);
        frame(64'h0000, 16);
        check(rx[15:0] == 16'hE122, "R10", "od resp", 32'(rx[15:0]), 32'hE122);

        // R11 arm on chip select falling edge only
        hw_reset(1'b0);
        shift_bits(64'hC0EE, 16);
        check(sdo_oe == 1'b0, "R11", "oe unarmed", 32'(sdo_oe), 0);
        cs_high();
        check(wp(0) == 8'h40, "R11", "w0 unarmed", 32'(wp(0)), 32'h40);
        frame(64'hC0EE, 16);
        check(wp(0) == 8'hEE, "R11", "w0 armed", 32'(wp(0)), 32'hEE);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule